// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Controller

This block is a byte-wide serial port that a small processor drives through four registers on a simple synchronous bus. A two-bit address selects one of four registers. Offset 0 is the data port, which takes transmit writes and returns received bytes on reads. Offset 1 holds the status flags. Offset 2 is the command register and offset 3 is the control register. A single transmitter and a single receiver move characters framed as one start bit, eight data bits sent least-significant first, and one stop bit, with no parity. Bit timing comes from a reference-rate strobe (nominally 1.8432 MHz). This strobe is divided to a 16x oversampling tick by a divisor that the control register selects. The tick is shared by both directions.

Two active-low modem inputs gate the serial traffic. `cts_n` keeps the transmitter from starting a character, and `dcd_n` disables the receiver, which discards any character still in flight when it goes inactive. The third modem input, `dsr_n`, can only be read back. The request-to-send and terminal-ready outputs follow the command register alone. A received character can raise an interrupt, which a status read clears. Any write to the status register acts as a programmed reset.

Top module: `acia_serial_ctrl`

## Requirements
- R1: Address 0 is data, 1 is status, 2 is command and 3 is control. The command and control registers read back the last value written to them.
- R2: After reset, with all modem inputs low, status reads 0x10, `txd` is 1, `rts_n` and `dtr_n` are 1 and `irq` is 0. The status layout is bit7 irq, bit6 `dsr_n` level, bit5 `dcd_n` level, bit4 transmit holding empty, bit3 receive full, bit2 overrun, bit1 framing error, bit0 always 0.
- R3: A byte written to address 0 is sent as start bit 0, eight data bits LSB first, then stop bit 1. Each bit lasts 16 ticks of the 16x clock. When control bit4 is 1, control bits 3:0 select how many reference strobes make one 16x tick. Selects 0 to 15 give 1, 2304, 1536, 1048, 856, 768, 384, 192, 96, 64, 48, 32, 24, 16, 12 and 6 strobes; for example, 0x1E gives 9600 baud. When control bit4 is 0 the divisor is 1.
- R4: While `cts_n` is 1, no character starts: `txd` stays 1 and status bit4 stays 0. Once `cts_n` goes low, the held byte is sent.
- R5: The receiver oversamples at 16x and confirms the start bit at mid-bit. It sets status bit3 and presents the byte at address 0. Reading address 0 clears bit3.
- R6: A character whose stop bit samples 0 sets status bit1.
- R7: A character that completes while bit3 is already set sets status bit2 (overrun). Address 0 keeps the earlier byte, and reading address 0 clears both bit2 and bit3.
- R8: The receiver runs only while command bit0 is 1 and `dcd_n` is 0. `dtr_n` is the inverse of command bit0. If `dcd_n` goes to 1 mid-character, that character is dropped.
- R9: `dsr_n` shows in status bit6 and `dcd_n` shows in status bit5. `dsr_n` has no effect on sending or receiving.
- R10: `rts_n` is 1 exactly when command bits 3:2 are 00, so command 0x0B gives `rts_n` = 0. It does not change when the receive buffer fills.
- R11: When command bit1 is 0, a received character sets `irq` and status bit7. When command bit1 is 1, `irq` stays 0. A read of status clears `irq`.
- R12: A write of any value to address 1 does the following: it clears command bits 4:0, the receive-full, overrun, framing and irq flags, drops an unsent held byte and stops both serial engines. The control register is left unchanged.
- R13: A low pulse on `rxd` that is gone by the mid-bit check is rejected, and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe at the reference bit-clock rate |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Receive interrupt request, active high |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| cts_n | input | 1 | Clear to send, active low, gates transmitter start |
| dcd_n | input | 1 | Carrier detect, active low, gates the receiver |
| dsr_n | input | 1 | Data set ready, active low, status only |
| rts_n | output | 1 | Request to send, active low, from command bits 3:2 |
| dtr_n | output | 1 | Terminal ready, active low, from command bit0 |

## Verification
The hardest state to reach from the ports is a receiver that `dcd_n` cuts off partway through a character. The bench drives `rxd` itself with bit-accurate timing, lifts `dcd_n` after the third data bit and lowers it once the line is idle. It then shows that no byte appeared and that a clean character that follows is received intact. Overrun is reached in a similar way: the bench sends two back-to-back frames with no data read between them. A soft reset with a byte stuck behind an inactive `cts_n` is built by holding `cts_n` high across the data write and the status write, then releasing it and watching `txd` stay idle.

// File: rtl/acia_pkg.sv
package acia_pkg;

    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);
    localparam int DIV_W    = 12;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    // command bit roles
    localparam int CMD_RX_ON    = 0;
    localparam int CMD_IRQ_MASK = 1;
    localparam int CMD_SOFT_W   = 5;   // bits below this clear on soft reset

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // reference strobes per 16x tick, picked by control bits 4:0
    function automatic logic [DIV_W-1:0] rate_divisor(input logic [4:0] sel);
        logic [DIV_W-1:0] r;
        if (!sel[4]) begin
            r = DIV_W'(1);
        end else begin
            case (sel[3:0])
                4'd0:    r = DIV_W'(1);
                4'd1:    r = DIV_W'(2304);
                4'd2:    r = DIV_W'(1536);
                4'd3:    r = DIV_W'(1048);
                4'd4:    r = DIV_W'(856);
                4'd5:    r = DIV_W'(768);
                4'd6:    r = DIV_W'(384);
                4'd7:    r = DIV_W'(192);
                4'd8:    r = DIV_W'(96);
                4'd9:    r = DIV_W'(64);
                4'd10:   r = DIV_W'(48);
                4'd11:   r = DIV_W'(32);
                4'd12:   r = DIV_W'(24);
                4'd13:   r = DIV_W'(16);
                4'd14:   r = DIV_W'(12);
                default: r = DIV_W'(6);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/acia_baud_gen.sv
module acia_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick16
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } bg_t;

    bg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (ref_tick) begin
            if (s_q.cnt >= div - DIV_W'(1)) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick16 = s_q.tick;

endmodule

// File: rtl/acia_tx.sv
module acia_tx
    import acia_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tick16,
    input  logic                 hold_full,
    input  logic [DATA_BITS-1:0] hold_data,
    input  logic                 cts_n,
    output logic                 take,
    output logic                 busy,
    output logic                 txd
);

    localparam int BIT_W = $clog2(DATA_BITS);

    typedef struct packed {
        tx_state_e            state;
        logic [OVS_W-1:0]     sub;
        logic [BIT_W-1:0]     bitn;
        logic [DATA_BITS-1:0] sh;
        logic                 line;
    } tx_t;

    tx_t s_d, s_q;
    logic take_c;

    always_comb begin
        s_d    = s_q;
        take_c = 1'b0;
        unique case (s_q.state)
            TX_IDLE: begin
                s_d.line = 1'b1;
                if (hold_full && !cts_n) begin
                    s_d.state = TX_START;
                    s_d.sh    = hold_data;
                    s_d.sub   = '0;
                    s_d.line  = 1'b0;
                    take_c    = 1'b1;
                end
            end
            TX_START: begin
                if (tick16) begin
                    if (s_q.sub == OVS_W'(OVS-1)) begin
                        s_d.state = TX_DATA;
                        s_d.sub   = '0;
                        s_d.bitn  = '0;
                        s_d.line  = s_q.sh[0];
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
            end
            TX_DATA: begin
                if (tick16) begin
                    if (s_q.sub == OVS_W'(OVS-1)) begin
                        s_d.sub = '0;
                        if (s_q.bitn == BIT_W'(DATA_BITS-1)) begin
                            s_d.state = TX_STOP;
                            s_d.line  = 1'b1;
                        end else begin
                            s_d.bitn = s_q.bitn + BIT_W'(1);
                            s_d.sh   = s_q.sh >> 1;
                            s_d.line = s_q.sh[1];
                        end
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
            end
            TX_STOP: begin
                if (tick16) begin
                    if (s_q.sub == OVS_W'(OVS-1)) begin
                        s_d.state = TX_IDLE;
                        s_d.sub   = '0;
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
            end
            default: s_d.state = TX_IDLE;
        endcase
        if (clr) begin
            s_d      = '0;
            s_d.line = 1'b1;
            take_c   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign take = take_c;
    assign busy = (s_q.state != TX_IDLE);
    assign txd  = s_q.line;

endmodule

// File: rtl/acia_rx.sv
module acia_rx
    import acia_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 enable,
    input  logic                 tick16,
    input  logic                 rxd,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 ferr
);

    localparam int BIT_W = $clog2(DATA_BITS);
    localparam int HALF  = OVS / 2;

    typedef struct packed {
        logic                 s1;
        logic                 s2;
        rx_state_e            state;
        logic [OVS_W-1:0]     sub;
        logic [BIT_W-1:0]     bitn;
        logic [DATA_BITS-1:0] sh;
        logic                 done;
        logic [DATA_BITS-1:0] data;
        logic                 ferr;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.s1   = rxd;
        s_d.s2   = s_q.s1;
        if (!enable || clr) begin
            s_d.state = RX_IDLE;
            s_d.sub   = '0;
            s_d.bitn  = '0;
        end else if (tick16) begin
            unique case (s_q.state)
                RX_IDLE: begin
                    if (!s_q.s2) begin
                        s_d.state = RX_START;
                        s_d.sub   = '0;
                    end
                end
                RX_START: begin
                    if (s_q.sub == OVS_W'(HALF-1)) begin
                        s_d.sub  = '0;
                        s_d.bitn = '0;
                        s_d.state = s_q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
                RX_DATA: begin
                    if (s_q.sub == OVS_W'(OVS-1)) begin
                        s_d.sub = '0;
                        s_d.sh  = {s_q.s2, s_q.sh[DATA_BITS-1:1]};
                        if (s_q.bitn == BIT_W'(DATA_BITS-1)) s_d.state = RX_STOP;
                        else                                 s_d.bitn  = s_q.bitn + BIT_W'(1);
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
                RX_STOP: begin
                    if (s_q.sub == OVS_W'(OVS-1)) begin
                        s_d.sub   = '0;
                        s_d.state = RX_IDLE;
                        s_d.done  = 1'b1;
                        s_d.data  = s_q.sh;
                        s_d.ferr  = ~s_q.s2;
                    end else begin
                        s_d.sub = s_q.sub + OVS_W'(1);
                    end
                end
                default: s_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.s1 <= 1'b1;
            s_q.s2 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign data = s_q.data;
    assign ferr = s_q.ferr;

endmodule

// File: rtl/acia_serial_ctrl.sv
module acia_serial_ctrl
    import acia_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       cs,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       txd,
    input  logic       rxd,
    input  logic       cts_n,
    input  logic       dcd_n,
    input  logic       dsr_n,
    output logic       rts_n,
    output logic       dtr_n
);

    typedef struct packed {
        logic [7:0]           cmd;
        logic [7:0]           ctrl;
        logic [DATA_BITS-1:0] hold;
        logic                 hold_full;
        logic [DATA_BITS-1:0] rx_buf;
        logic                 rx_full;
        logic                 ovr;
        logic                 ferr;
        logic                 irq;
    } regs_t;

    regs_t r_d, r_q;

    logic                 soft_rst;
    logic                 rd_data, rd_stat;
    logic                 tick16;
    logic [DIV_W-1:0]     div;
    logic                 tx_take, tx_busy;
    logic                 rx_en, rx_done, rx_ferr;
    logic [DATA_BITS-1:0] rx_data;
    logic [7:0]           status;
    logic [7:0]           cmd_cur;
    logic                 rx_full_cur, ovr_cur;

    assign soft_rst = cs & we & (addr == ADDR_STAT);
    assign rd_data  = cs & ~we & (addr == ADDR_DATA);
    assign rd_stat  = cs & ~we & (addr == ADDR_STAT);
    assign div      = rate_divisor(r_q.ctrl[4:0]);
    assign rx_en    = r_q.cmd[CMD_RX_ON] & ~dcd_n;

    acia_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .clr      (soft_rst),
        .div      (div),
        .tick16   (tick16)
    );

    acia_tx #(.DATA_BITS(DATA_BITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .tick16    (tick16),
        .hold_full (r_q.hold_full),
        .hold_data (r_q.hold),
        .cts_n     (cts_n),
        .take      (tx_take),
        .busy      (tx_busy),
        .txd       (txd)
    );

    acia_rx #(.DATA_BITS(DATA_BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .enable (rx_en),
        .tick16 (tick16),
        .rxd    (rxd),
        .done   (rx_done),
        .data   (rx_data),
        .ferr   (rx_ferr)
    );

    always_comb begin
        r_d = r_q;
        if (tx_take) r_d.hold_full = 1'b0;
        if (rd_data) begin
            r_d.rx_full = 1'b0;
            r_d.ovr     = 1'b0;
        end
        if (rd_stat) r_d.irq = 1'b0;
        if (rx_done) begin
            if (r_q.rx_full && !rd_data) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.rx_buf  = rx_data;
                r_d.rx_full = 1'b1;
                r_d.ferr    = rx_ferr;
            end
            if (!r_q.cmd[CMD_IRQ_MASK]) r_d.irq = 1'b1;
        end
        if (cs && we) begin
            unique case (addr)
                ADDR_DATA: begin
                    r_d.hold      = wdata[DATA_BITS-1:0];
                    r_d.hold_full = 1'b1;
                end
                ADDR_CMD:  r_d.cmd  = wdata;
                ADDR_CTRL: r_d.ctrl = wdata;
                default:   ;
            endcase
        end
        if (soft_rst) begin
            r_d.cmd[CMD_SOFT_W-1:0] = '0;
            r_d.hold_full = 1'b0;
            r_d.rx_full   = 1'b0;
            r_d.ovr       = 1'b0;
            r_d.ferr      = 1'b0;
            r_d.irq       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = {r_q.irq, dsr_n, dcd_n, ~r_q.hold_full,
                     r_q.rx_full, r_q.ovr, r_q.ferr, 1'b0};

    always_comb begin
        unique case (addr)
            ADDR_DATA: rdata = 8'(r_q.rx_buf);
            ADDR_STAT: rdata = status;
            ADDR_CMD:  rdata = r_q.cmd;
            default:   rdata = r_q.ctrl;
        endcase
    end

    assign irq         = r_q.irq;
    assign rts_n       = (r_q.cmd[3:2] == 2'b00);
    assign dtr_n       = ~r_q.cmd[CMD_RX_ON];
    assign cmd_cur     = r_q.cmd;
    assign rx_full_cur = r_q.rx_full;
    assign ovr_cur     = r_q.ovr;

endmodule

// File: rtl/acia_serial_ctrl_chk.sv
module acia_serial_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       we,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       irq,
    input logic       rts_n,
    input logic       dtr_n,
    input logic       cts_n,
    input logic       dcd_n,
    input logic       tx_busy,
    input logic       rx_done,
    input logic [7:0] cmd_cur,
    input logic       rx_full_cur,
    input logic       ovr_cur
);

    AST_TX_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(cts_n)); // R4

    AST_RTS_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr == 2'd2) |=> (rts_n == ($past(wdata[3:2]) == 2'b00))); // R10

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr == 2'd1) |=> (!rx_full_cur && !ovr_cur && !irq && dtr_n && rts_n)); // R12

    AST_IRQ_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(cmd_cur[1])); // R11

    AST_IRQ_CLEARED_BY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr == 2'd1 && !rx_done) |=> !irq); // R11

    AST_NO_RX_WITHOUT_DCD: assert property (@(posedge clk) disable iff (!rst_n)
        dcd_n |=> !rx_done); // R8

endmodule

bind acia_serial_ctrl acia_serial_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .we          (we),
    .addr        (addr),
    .wdata       (wdata),
    .irq         (irq),
    .rts_n       (rts_n),
    .dtr_n       (dtr_n),
    .cts_n       (cts_n),
    .dcd_n       (dcd_n),
    .tx_busy     (tx_busy),
    .rx_done     (rx_done),
    .cmd_cur     (cmd_cur),
    .rx_full_cur (rx_full_cur),
    .ovr_cur     (ovr_cur)
);

// File: tb/acia_serial_ctrl_tb.sv
module acia_serial_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, txd, rts_n, dtr_n;
    logic       cts_n = 1'b0, dcd_n = 1'b0, dsr_n = 1'b0;
    logic       rxd_b = 1'b1, loop_en = 1'b0;
    logic       rxd;
    logic       mon_en = 1'b0, saw_low = 1'b0;
    int         tests = 0, fails = 0;

    always #5 clk = ~clk;

    assign rxd = loop_en ? txd : rxd_b;

    acia_serial_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(1'b1),
        .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .txd(txd), .rxd(rxd),
        .cts_n(cts_n), .dcd_n(dcd_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    always @(negedge clk) if (mon_en && txd == 1'b0) saw_low <= 1'b1;

    // {control, byte, dsr_n, bit length in clocks}
    localparam logic [31:0] VEC [6] = '{
        {8'h10, 8'hA5, 4'h0, 12'd16},
        {8'h1F, 8'h3C, 4'h1, 12'd96},
        {8'h1E, 8'h2A, 4'h0, 12'd192},
        {8'h1D, 8'hFF, 4'h1, 12'd256},
        {8'h00, 8'h00, 4'h0, 12'd16},
        {8'h1C, 8'h81, 4'h0, 12'd384}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk); cs = 1'b0;
    endtask

    task automatic drive(input logic v, input int n);
        rxd_b = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int bitc, input logic stop_ok);
        @(negedge clk);
        drive(1'b0, bitc);
        for (int i = 0; i < 8; i++) drive(b[i], bitc);
        if (stop_ok) drive(1'b1, bitc);
        else         drive(1'b0, bitc/2 + 4);
        drive(1'b1, 2*bitc);
    endtask

    task automatic capture_tx(input int bitc, output logic [7:0] b, output logic stop);
        int t = 0;
        b = 8'h00; stop = 1'b0;
        @(negedge clk);
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        repeat (bitc/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bitc) @(negedge clk);
            b[i] = txd;
        end
        repeat (bitc) @(negedge clk);
        stop = txd;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v, b;
        logic       st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(2'd1, v); chk("R2 status", v, 8'h10);
        chk("R2 txd", {7'd0, txd}, 8'd1);
        chk("R2 rts_n/dtr_n/irq", {5'd0, rts_n, dtr_n, irq}, 8'b110);

        // R1 register map read-back
        wr(2'd2, 8'h0B); wr(2'd3, 8'h10);
        rd(2'd2, v); chk("R1 command", v, 8'h0B);
        rd(2'd3, v); chk("R1 control", v, 8'h10);
        chk("R10 rts_n for 0x0B", {7'd0, rts_n}, 8'd0);
        chk("R8 dtr_n for bit0=1", {7'd0, dtr_n}, 8'd0);

        // R3/R5/R9 loopback table
        loop_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            dsr_n = VEC[k][12];
            wr(2'd3, VEC[k][31:24]);
            wr(2'd0, VEC[k][23:16]);
            capture_tx(int'(VEC[k][11:0]), b, st);
            chk($sformatf("R3 tx byte vec%0d", k), b, VEC[k][23:16]);
            chk($sformatf("R3 stop bit vec%0d", k), {7'd0, st}, 8'd1);
            repeat (int'(VEC[k][11:0])) @(negedge clk);
            rd(2'd1, v); chk($sformatf("R5 rx full vec%0d", k), {7'd0, v[3]}, 8'd1);
            chk($sformatf("R9 dsr bit vec%0d", k), {7'd0, v[6]}, {7'd0, VEC[k][12]});
            rd(2'd0, v); chk($sformatf("R5 rx byte vec%0d", k), v, VEC[k][23:16]);
            rd(2'd1, v); chk($sformatf("R5 cleared vec%0d", k), {7'd0, v[3]}, 8'd0);
        end
        loop_en = 1'b0; dsr_n = 1'b0;
        wr(2'd3, 8'h10);

        // R9 dcd level visible
        dcd_n = 1'b1; rd(2'd1, v); chk("R9 dcd bit", {7'd0, v[5]}, 8'd1);

        // R8 receiver off while dcd_n high
        send_frame(8'h66, 16, 1'b1);
        rd(2'd1, v); chk("R8 no rx with dcd_n high", {7'd0, v[3]}, 8'd0);
        dcd_n = 1'b0;

        // R8 dcd rises mid-character: discard, then clean frame
        @(negedge clk);
        drive(1'b0, 16);
        for (int i = 0; i < 3; i++) drive(1'b1, 16);
        dcd_n = 1'b1;
        for (int i = 3; i < 8; i++) drive(1'b0, 16);
        drive(1'b1, 48);
        dcd_n = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R8 mid-char discard", {7'd0, v[3]}, 8'd0);
        send_frame(8'hC3, 16, 1'b1);
        rd(2'd0, v); chk("R8 clean frame after discard", v, 8'hC3);

        // R13 glitch rejected
        @(negedge clk); drive(1'b0, 3); drive(1'b1, 60);
        rd(2'd1, v); chk("R13 glitch ignored", {7'd0, v[3]}, 8'd0);

        // R11 irq unmasked
        wr(2'd2, 8'h09);
        send_frame(8'h5A, 16, 1'b1);
        chk("R11 irq set", {7'd0, irq}, 8'd1);
        rd(2'd1, v); chk("R11 status bit7", {7'd0, v[7]}, 8'd1);
        chk("R11 irq cleared by status read", {7'd0, irq}, 8'd0);
        rd(2'd0, v); chk("R5 byte 5A", v, 8'h5A);

        // R11 masked, R10 rts unaffected by full buffer
        wr(2'd2, 8'h0B);
        send_frame(8'h3E, 16, 1'b1);
        chk("R11 irq masked", {7'd0, irq}, 8'd0);
        chk("R10 rts_n with rx full", {7'd0, rts_n}, 8'd0);
        rd(2'd0, v);

        // R7 overrun
        send_frame(8'h11, 16, 1'b1);
        send_frame(8'h22, 16, 1'b1);
        rd(2'd1, v); chk("R7 overrun + full", v & 8'h0C, 8'h0C);
        rd(2'd0, v); chk("R7 first byte kept", v, 8'h11);
        rd(2'd1, v); chk("R7 flags cleared", v & 8'h0C, 8'h00);

        // R6 framing error
        send_frame(8'h4D, 16, 1'b0);
        rd(2'd1, v); chk("R6 framing bit", {7'd0, v[1]}, 8'd1);
        rd(2'd0, v);

        // R4 CTS gating
        cts_n = 1'b1; saw_low = 1'b0; mon_en = 1'b1;
        wr(2'd0, 8'h77);
        repeat (200) @(negedge clk);
        mon_en = 1'b0;
        chk("R4 txd idle while cts_n high", {7'd0, saw_low}, 8'd0);
        rd(2'd1, v); chk("R4 holding not empty", {7'd0, v[4]}, 8'd0);
        cts_n = 1'b0;
        capture_tx(16, b, st);
        chk("R4 byte after cts_n low", b, 8'h77);
        repeat (40) @(negedge clk);

        // R12 soft reset
        send_frame(8'h99, 16, 1'b1);
        cts_n = 1'b1;
        wr(2'd0, 8'h55);
        wr(2'd3, 8'h1E);
        wr(2'd1, 8'hA7);
        rd(2'd2, v); chk("R12 command cleared", v, 8'h00);
        rd(2'd3, v); chk("R12 control kept", v, 8'h1E);
        rd(2'd1, v); chk("R12 status", v, 8'h10);
        chk("R12 rts_n/dtr_n", {6'd0, rts_n, dtr_n}, 8'b11);
        saw_low = 1'b0; mon_en = 1'b1; cts_n = 1'b0;
        repeat (300) @(negedge clk);
        mon_en = 1'b0;
        chk("R12 held byte dropped", {7'd0, saw_low}, 8'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule